// File: doc/BRIEF.md
# Time-Multiplexed Three-Read / Two-Write Register File

This block is a small register file that offers three read ports and two write ports per operation, built on a single narrow-ported RAM. It does not replicate storage in flip-flops. Each operation is a macro-cycle of several internal RAM cycles. The two retiring results are written first, and the three new operands are then read. A read therefore returns a value retired in the same macro-cycle.

An operation starts with a one-cycle start strobe. In that clock the block latches both write requests and all three read addresses, so the inputs are free to change afterwards. While the operation runs, busy is high. A one-cycle done pulse marks new read data.

The parameter `DUAL_PORT` picks the variant:
- **Two-port RAM:** both writes share the first RAM cycle, and the three reads take the next two cycles.
- **Single-port RAM:** writes and reads go one per RAM cycle, which needs more cycles per macro-cycle.

The macro-cycle length sets the throughput of whatever uses the block.

Top module: `tmux_regfile`

## Requirements
- R1: The three read outputs return the register contents at the three read addresses latched on the accepted start strobe. Changing the address or write inputs after that clock has no effect on the operation. Two or three read ports may name the same register.
- R2: Both writes of an operation complete before its reads. A read of a register written in the same operation returns the new value.
- R3: When both write enables are set and both write addresses are equal, the register ends up holding write port 1's data.
- R4: A write port whose enable was low on the accepted start strobe leaves its target register unchanged.
- R5: In the two-port variant (`DUAL_PORT`=1), busy is high for exactly 3 cycles after the clock edge that accepts start. Done is high for exactly one cycle, the 3rd cycle after that edge. In that cycle busy is already low and the new read data are present.
- R6: The read outputs change only in a cycle in which done is high. They hold their values from one done pulse until the next.
- R7: A start strobe seen while busy is high is ignored. It does not extend or restart the operation, its write requests are not performed, and it yields no extra done pulse.
- R8: After reset, done and busy are low and all three read outputs are zero.
- R9: In the single-port variant (`DUAL_PORT`=0), results are identical to the two-port variant. Busy lasts 5 cycles and done falls in the 5th cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a macro-cycle when busy is low |
| wrEn0 | input | 1 | Write port 0 enable |
| wrAddr0 | input | ADDR_W | Write port 0 register index |
| wrData0 | input | DATA_W | Write port 0 data |
| wrEn1 | input | 1 | Write port 1 enable (wins on equal addresses) |
| wrAddr1 | input | ADDR_W | Write port 1 register index |
| wrData1 | input | DATA_W | Write port 1 data |
| rdAddr0 | input | ADDR_W | Read port 0 register index |
| rdAddr1 | input | ADDR_W | Read port 1 register index |
| rdAddr2 | input | ADDR_W | Read port 2 register index |
| rdData0 | output | DATA_W | Read port 0 result |
| rdData1 | output | DATA_W | Read port 1 result |
| rdData2 | output | DATA_W | Read port 2 result |
| done | output | 1 | One-cycle pulse when new read data are present |
| busy | output | 1 | High while a macro-cycle is in progress |

## Verification
Both variants get the same sequence of operations, and each is compared against a simple array model. The sequence contains these patterns:
- **Filling operations:** each writes two distinct registers and reads them back. These show that writes land before reads.
- **Equal-address double write:** this separates "port 1 wins" from the reverse priority.
- **Disabled write enables:** these show that writes are gated by their enable.
- **Repeated read addresses:** these show that each read port is steered to its own output.

Inputs are scrambled right after each accepted start, which exposes any use of unlatched inputs. A start pulsed in the middle of an operation, carrying enabled garbage writes, is followed by a read of the garbage target. This separates an ignored strobe from an accepted one. Every operation also checks the done cycle against the variant's latency and checks that the outputs hold until done.

// File: rtl/tmux_regfile_pkg.sv
`timescale 1ns/1ps
package tmux_regfile_pkg;

  // Strobes issued by the sequencer for one internal RAM cycle.
  typedef struct packed {
    logic       aWr;     // port A performs a write this cycle
    logic       aWrSel;  // which latched write request port A carries
    logic       bWr;     // port B writes latched request 1
    logic       aRd;     // port A performs a read this cycle
    logic [1:0] aRdSel;  // read operand index served by port A
    logic       bRd;     // port B performs a read this cycle
    logic [1:0] bRdSel;  // read operand index served by port B
    logic       commit;  // last slot: publish staged operands
  } slotCmd_t;

endpackage

// File: rtl/tmux_regfile_ctrl.sv
`timescale 1ns/1ps
module tmux_regfile_ctrl
  import tmux_regfile_pkg::*;
#(
  parameter bit DUAL_PORT = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output logic     load,
  output logic     busy,
  output logic     done,
  output slotCmd_t cmd
);

  localparam int LAT    = DUAL_PORT ? 3 : 5;
  localparam int SLOT_W = $clog2(LAT);

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              doneQ;

  assign load = start && !active;
  assign busy = active;
  assign done = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      slot   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (load) begin
        active <= 1'b1;
        slot   <= '0;
      end else if (active) begin
        if (slot == SLOT_W'(LAT - 1)) begin
          active <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  generate
    if (DUAL_PORT) begin : g_twoPortSched
      always_comb begin
        cmd = '0;
        if (active) begin
          case (slot)
            SLOT_W'(0): begin
              cmd.aWr    = 1'b1;
              cmd.aWrSel = 1'b0;
              cmd.bWr    = 1'b1;
            end
            SLOT_W'(1): begin
              cmd.aRd    = 1'b1;
              cmd.aRdSel = 2'd0;
              cmd.bRd    = 1'b1;
              cmd.bRdSel = 2'd1;
            end
            SLOT_W'(2): begin
              cmd.aRd    = 1'b1;
              cmd.aRdSel = 2'd2;
              cmd.commit = 1'b1;
            end
            default: cmd = '0;
          endcase
        end
      end
    end else begin : g_onePortSched
      always_comb begin
        cmd = '0;
        if (active) begin
          case (slot)
            SLOT_W'(0): begin
              cmd.aWr    = 1'b1;
              cmd.aWrSel = 1'b0;
            end
            SLOT_W'(1): begin
              cmd.aWr    = 1'b1;
              cmd.aWrSel = 1'b1;
            end
            SLOT_W'(2): begin
              cmd.aRd    = 1'b1;
              cmd.aRdSel = 2'd0;
            end
            SLOT_W'(3): begin
              cmd.aRd    = 1'b1;
              cmd.aRdSel = 2'd1;
            end
            SLOT_W'(4): begin
              cmd.aRd    = 1'b1;
              cmd.aRdSel = 2'd2;
              cmd.commit = 1'b1;
            end
            default: cmd = '0;
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/tmux_regfile_ram.sv
`timescale 1ns/1ps
module tmux_regfile_ram #(
  parameter int NUM_REGS  = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter bit DUAL_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  // Read data is sampled by the operand stage at the end of the slot,
  // which acts as the RAM's output register.
  assign aRdata = mem[aAddr];

  generate
    if (DUAL_PORT) begin : g_twoPort
      always_ff @(posedge clk) begin
        if (aWe) mem[aAddr] <= aWdata;
        if (bWe) mem[bAddr] <= bWdata;
      end
      assign bRdata = mem[bAddr];
    end else begin : g_onePort
      always_ff @(posedge clk) begin
        if (aWe) mem[aAddr] <= aWdata;
      end
      assign bRdata = '0;
    end
  endgenerate

endmodule

// File: rtl/tmux_regfile_dp.sv
`timescale 1ns/1ps
module tmux_regfile_dp
  import tmux_regfile_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  slotCmd_t          cmd,
  input  logic              wrEn0,
  input  logic [ADDR_W-1:0] wrAddr0,
  input  logic [DATA_W-1:0] wrData0,
  input  logic              wrEn1,
  input  logic [ADDR_W-1:0] wrAddr1,
  input  logic [DATA_W-1:0] wrData1,
  input  logic [ADDR_W-1:0] rdAddr0,
  input  logic [ADDR_W-1:0] rdAddr1,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic              aWe,
  output logic [ADDR_W-1:0] aAddr,
  output logic [DATA_W-1:0] aWdata,
  input  logic [DATA_W-1:0] aRdata,
  output logic              bWe,
  output logic [ADDR_W-1:0] bAddr,
  output logic [DATA_W-1:0] bWdata,
  input  logic [DATA_W-1:0] bRdata,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2
);

  localparam int NUM_WR = 2;
  localparam int NUM_RD = 3;

  logic              reqWrEn   [NUM_WR];
  logic [ADDR_W-1:0] reqWrAddr [NUM_WR];
  logic [DATA_W-1:0] reqWrData [NUM_WR];
  logic [ADDR_W-1:0] reqRdAddr [NUM_RD];
  logic [DATA_W-1:0] stage     [NUM_RD];
  logic [DATA_W-1:0] outQ      [NUM_RD];
  logic              port0Shadowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WR; i++) begin
        reqWrEn[i]   <= 1'b0;
        reqWrAddr[i] <= '0;
        reqWrData[i] <= '0;
      end
      for (int i = 0; i < NUM_RD; i++) reqRdAddr[i] <= '0;
    end else if (load) begin
      reqWrEn[0]   <= wrEn0;
      reqWrAddr[0] <= wrAddr0;
      reqWrData[0] <= wrData0;
      reqWrEn[1]   <= wrEn1;
      reqWrAddr[1] <= wrAddr1;
      reqWrData[1] <= wrData1;
      reqRdAddr[0] <= rdAddr0;
      reqRdAddr[1] <= rdAddr1;
      reqRdAddr[2] <= rdAddr2;
    end
  end

  // Port 1 has priority: drop port 0's write when both hit one register.
  assign port0Shadowed = reqWrEn[1] && (reqWrAddr[0] == reqWrAddr[1]);

  always_comb begin
    aWe    = 1'b0;
    aAddr  = reqRdAddr[cmd.aRdSel];
    aWdata = reqWrData[cmd.aWrSel];
    if (cmd.aWr) begin
      aAddr = reqWrAddr[cmd.aWrSel];
      aWe   = cmd.aWrSel ? reqWrEn[1] : (reqWrEn[0] && !port0Shadowed);
    end
  end

  assign bWe    = cmd.bWr && reqWrEn[1];
  assign bAddr  = cmd.bWr ? reqWrAddr[1] : reqRdAddr[cmd.bRdSel];
  assign bWdata = reqWrData[1];

  generate
    for (genvar i = 0; i < NUM_RD; i++) begin : g_operand
      logic              capA;
      logic              capB;
      logic [DATA_W-1:0] nextVal;

      assign capA    = cmd.aRd && (cmd.aRdSel == 2'(i));
      assign capB    = cmd.bRd && (cmd.bRdSel == 2'(i));
      assign nextVal = capA ? aRdata : (capB ? bRdata : stage[i]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[i] <= '0;
          outQ[i]  <= '0;
        end else begin
          if (capA || capB) stage[i] <= nextVal;
          if (cmd.commit)   outQ[i]  <= nextVal;
        end
      end
    end
  endgenerate

  assign rdData0 = outQ[0];
  assign rdData1 = outQ[1];
  assign rdData2 = outQ[2];

endmodule

// File: rtl/tmux_regfile.sv
`timescale 1ns/1ps
module tmux_regfile
  import tmux_regfile_pkg::*;
#(
  parameter  int NUM_REGS  = 16,
  parameter  int DATA_W    = 16,
  parameter  bit DUAL_PORT = 1'b1,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn0,
  input  logic [ADDR_W-1:0] wrAddr0,
  input  logic [DATA_W-1:0] wrData0,
  input  logic              wrEn1,
  input  logic [ADDR_W-1:0] wrAddr1,
  input  logic [DATA_W-1:0] wrData1,
  input  logic [ADDR_W-1:0] rdAddr0,
  input  logic [ADDR_W-1:0] rdAddr1,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic [DATA_W-1:0] rdData0,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2,
  output logic              done,
  output logic              busy
);

  slotCmd_t          cmd;
  logic              load;
  logic              aWe, bWe;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic [DATA_W-1:0] aWdata, bWdata, aRdata, bRdata;

  tmux_regfile_ctrl #(.DUAL_PORT(DUAL_PORT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .load(load), .busy(busy), .done(done), .cmd(cmd)
  );

  tmux_regfile_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .load(load), .cmd(cmd),
    .wrEn0(wrEn0), .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrEn1(wrEn1), .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdAddr2(rdAddr2),
    .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .rdData0(rdData0), .rdData1(rdData1), .rdData2(rdData2)
  );

  tmux_regfile_ram #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DUAL_PORT(DUAL_PORT)
  ) u_ram (
    .clk(clk),
    .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata)
  );

endmodule

// File: rtl/tmux_regfile_chk.sv
`timescale 1ns/1ps
module tmux_regfile_chk #(
  parameter int DATA_W    = 16,
  parameter bit DUAL_PORT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData0,
  input logic [DATA_W-1:0] rdData1,
  input logic [DATA_W-1:0] rdData2
);

  localparam int LAT = DUAL_PORT ? 3 : 5;

  logic [3:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5 R7 R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 4'(LAT)));

  // R5
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6
  hold0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData0));

  // R6
  hold1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData1));

  // R6
  hold2_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData2));

endmodule

bind tmux_regfile tmux_regfile_chk #(.DATA_W(DATA_W), .DUAL_PORT(DUAL_PORT)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .rdData0(rdData0), .rdData1(rdData1), .rdData2(rdData2)
);

// File: tb/tmux_regfile_test.sv
`timescale 1ns/1ps
module tmux_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wrEn0 = 1'b0, wrEn1 = 1'b0;
  logic [3:0]  wrAddr0 = '0, wrAddr1 = '0;
  logic [15:0] wrData0 = '0, wrData1 = '0;
  logic [3:0]  rdAddr0 = '0, rdAddr1 = '0, rdAddr2 = '0;
  logic [15:0] dRd0, dRd1, dRd2, sRd0, sRd1, sRd2;
  logic        dDone, dBusy, sDone, sBusy;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;
  logic [15:0] refMem [16];

  always #2.5 clk = ~clk;

  tmux_regfile #(.DUAL_PORT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .wrEn0(wrEn0), .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrEn1(wrEn1), .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdAddr2(rdAddr2),
    .rdData0(dRd0), .rdData1(dRd1), .rdData2(dRd2),
    .done(dDone), .busy(dBusy)
  );

  tmux_regfile #(.DUAL_PORT(1'b0)) uutSp (
    .clk(clk), .rstN(rstN), .start(start),
    .wrEn0(wrEn0), .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrEn1(wrEn1), .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdAddr2(rdAddr2),
    .rdData0(sRd0), .rdData1(sRd1), .rdData2(sRd2),
    .done(sDone), .busy(sBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic resetState();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "two-port done",  int'(dDone), 0);
    check("R8", "two-port busy",  int'(dBusy), 0);
    check("R8", "two-port data",  int'(dRd0 | dRd1 | dRd2), 0);
    check("R8", "one-port done",  int'(sDone), 0);
    check("R8", "one-port busy",  int'(sBusy), 0);
    check("R8", "one-port data",  int'(sRd0 | sRd1 | sRd2), 0);
  endtask

  task automatic runOp(input bit e0, input logic [3:0] a0, input logic [15:0] d0,
                       input bit e1, input logic [3:0] a1, input logic [15:0] d1,
                       input logic [3:0] r0, input logic [3:0] r1, input logic [3:0] r2,
                       input bit ghost, input string req);
    logic [15:0] exp0, exp1, exp2;
    logic [15:0] pd0, pd1, pd2, ps0, ps1, ps2;
    int atD = -1, atS = -1, nD = 0, nS = 0;
    bit holdD = 1'b1, holdS = 1'b1;
    pd0 = dRd0; pd1 = dRd1; pd2 = dRd2;
    ps0 = sRd0; ps1 = sRd1; ps2 = sRd2;
    if (e0) refMem[a0] = d0;
    if (e1) refMem[a1] = d1;
    exp0 = refMem[r0]; exp1 = refMem[r1]; exp2 = refMem[r2];
    @(negedge clk);
    start = 1'b1;
    wrEn0 = e0; wrAddr0 = a0; wrData0 = d0;
    wrEn1 = e1; wrAddr1 = a1; wrData1 = d1;
    rdAddr0 = r0; rdAddr1 = r1; rdAddr2 = r2;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = ghost;
        wrEn0 = 1'b1; wrAddr0 = ~a0; wrData0 = ~d0;
        wrEn1 = 1'b1; wrAddr1 = ~a1; wrData1 = ~d1;
        rdAddr0 = ~r0; rdAddr1 = ~r1; rdAddr2 = ~r2;
      end else begin
        start = 1'b0;
        wrEn0 = 1'b0; wrEn1 = 1'b0;
      end
      if (dDone) begin
        nD++;
        if (atD < 0) begin
          atD = k;
          check(req, "two-port rd0", int'(dRd0), int'(exp0));
          check(req, "two-port rd1", int'(dRd1), int'(exp1));
          check(req, "two-port rd2", int'(dRd2), int'(exp2));
        end
      end else if (atD < 0 && (dRd0 != pd0 || dRd1 != pd1 || dRd2 != pd2)) begin
        holdD = 1'b0;
      end
      if (sDone) begin
        nS++;
        if (atS < 0) begin
          atS = k;
          check(req, "one-port rd0", int'(sRd0), int'(exp0));
          check(req, "one-port rd1", int'(sRd1), int'(exp1));
          check(req, "one-port rd2", int'(sRd2), int'(exp2));
        end
      end else if (atS < 0 && (sRd0 != ps0 || sRd1 != ps1 || sRd2 != ps2)) begin
        holdS = 1'b0;
      end
    end
    check("R5", "two-port done cycle", atD, 3);
    check("R9", "one-port done cycle", atS, 5);
    check("R7", "two-port done pulses", nD, 1);
    check("R7", "one-port done pulses", nS, 1);
    check("R6", "two-port hold", int'(holdD), 1);
    check("R6", "one-port hold", int'(holdS), 1);
  endtask

  task automatic fillAll();
    for (int i = 0; i < 8; i++) begin
      runOp(1'b1, 4'(2*i), 16'(16'hA000 + 16'(i * 16'h0111)),
            1'b1, 4'(2*i+1), 16'(16'h5000 + 16'(i * 16'h0203)),
            4'(2*i), 4'(2*i+1), 4'd0, 1'b0, "R1");
    end
  endtask

  task automatic readAfterWrite();
    runOp(1'b1, 4'd3, 16'h1234, 1'b1, 4'd7, 16'h5678, 4'd7, 4'd3, 4'd3, 1'b0, "R2");
  endtask

  task automatic sameAddrWrite();
    runOp(1'b1, 4'd5, 16'hDEAD, 1'b1, 4'd5, 16'hBEEF, 4'd5, 4'd4, 4'd5, 1'b0, "R3");
  endtask

  task automatic disabledWrite();
    runOp(1'b0, 4'd9, 16'hFFFF, 1'b1, 4'd10, 16'h0AB0, 4'd9, 4'd10, 4'd9, 1'b0, "R4");
    runOp(1'b0, 4'd1, 16'h1111, 1'b0, 4'd2, 16'h2222, 4'd1, 4'd2, 4'd15, 1'b0, "R4");
  endtask

  task automatic repeatedRead();
    runOp(1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000, 4'd6, 4'd6, 4'd6, 1'b0, "R1");
  endtask

  task automatic ignoredStart();
    // the mid-operation strobe carries enabled writes to registers 3 and 2
    runOp(1'b1, 4'd12, 16'h1111, 1'b0, 4'd13, 16'h2222, 4'd12, 4'd13, 4'd0, 1'b1, "R7");
    runOp(1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000, 4'd3, 4'd2, 4'd13, 1'b0, "R7");
  endtask

  initial begin
    resetState();
    fillAll();
    readAfterWrite();
    sameAddrWrite();
    disabledWrite();
    repeatedRead();
    ignoredStart();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule